// File: doc/BRIEF.md
# Reset Cause and Retention Control Registers

This block is the software-visible register set of a reset controller, reached over a 16-bit-data APB slave port. It keeps one sticky flag for each reset cause: power-on, external pin, watchdog expiry and software/system request. A flag is set by a one-cycle event pulse from the reset generator, and software clears it by writing 1 to its bit. The flags survive every reset except power-on. A power-on reset clears the other flags and leaves only the power-on flag set, so software can tell a cold start from a warm one.

A single retention bit drives the `no_retain` output. When the bit is 0, pin and programmable-logic state is kept across watchdog and software resets. When it is 1, that state is not kept. The bit is guarded by a key register. A write to the retention register takes effect only if it comes right after the first key value and then the second key value, each written to the key register. Any other write in between closes the lock again.

Register map (byte offsets): retention register at 0x0, key register at 0x4, cause flags at 0x8. A write is taken in the APB access phase, when `psel`, `penable` and `pwrite` are all high.

Top module: `rstctl_regs`

## Requirements
- R1: On power-on reset (`por_n` low), the cause register reads 0x0001 (only bit 0, power-on, set), the retention register reads 0, `no_retain` is 0 and the lock is closed.
- R2: A high cycle on `evt_ext`, `evt_wdt` or `evt_sw` sets cause bit 1, bit 2 or bit 3 respectively, at the next clock edge. The bit then stays set until software clears it.
- R3: Writing a 1 to a bit of the cause register at 0x8 clears that flag. Writing a 0 leaves the flag unchanged. Cause-register bits [15:4] always read 0.
- R4: When an event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: A write to the retention register at 0x0 while the lock is closed has no effect on the register or on `no_retain`.
- R6: Writing 0x2009 and then 0x0426 to the key register at 0x4, followed by a write to 0x0, loads bit 0 of the write data into the retention register. `no_retain` shows the new value from the clock edge that takes the write.
- R7: After one accepted retention write the lock closes, so a second retention write without a new key sequence is ignored.
- R8: A wrong value at either key step closes the lock. Writing the first key again while waiting for the second key keeps the sequence at the "first key received" step.
- R9: A write to any address other than 0x0 or 0x4 (the cause register or an unmapped address) while the sequence is partly or fully done closes the lock.
- R10: The key register always reads 0x0000.
- R11: Reads from any register do not disturb the unlock sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | APB clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when high |
| paddr | input | 4 | APB byte address |
| pwdata | input | 16 | APB write data |
| prdata | output | 16 | APB read data |
| evt_ext | input | 1 | External reset event pulse |
| evt_wdt | input | 1 | Watchdog timeout event pulse |
| evt_sw | input | 1 | Software/system reset event pulse |
| no_retain | output | 1 | 1 = state is not retained across watchdog/software reset |

## Verification
The bench uses the default parameters: a 4-bit address, the key pair 0x2009/0x0426, and the offsets 0x0, 0x4 and 0x8. The 4-bit address leaves 0xC free as an unmapped address, so a relock caused by a write outside the map can be tested as well as a relock caused by a cause-register write. Having both key values fixed and distinct lets the bench test a repeated first key, a wrong first key and a wrong second key as separate paths through the unlock sequence. A power-on reset in the middle of the run, taken while the retention bit is set and warm-reset flags are present, shows that the bit and those flags are cleared only by power-on.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

  localparam int DATA_W = 16;
  localparam int N_SRC  = 4;

  // cause bit positions
  localparam int SRC_POR = 0;
  localparam int SRC_EXT = 1;
  localparam int SRC_WDT = 2;
  localparam int SRC_SW  = 3;

  typedef enum logic [1:0] {
    UL_LOCKED = 2'd0,
    UL_KEY1   = 2'd1,
    UL_OPEN   = 2'd2
  } unlock_e;

  // next step of the unlock sequence for one bus cycle
  function automatic unlock_e unlock_next(
    input unlock_e            cur,
    input logic               wr_key,
    input logic               wr_cfg,
    input logic               wr_foreign,
    input logic [DATA_W-1:0]  wdata,
    input logic [DATA_W-1:0]  key_a,
    input logic [DATA_W-1:0]  key_b
  );
    unlock_e nxt;
    nxt = cur;
    if (wr_key) begin
      if (wdata == key_a)                          nxt = UL_KEY1;
      else if (cur == UL_KEY1 && wdata == key_b)   nxt = UL_OPEN;
      else                                         nxt = UL_LOCKED;
    end else if (wr_cfg || wr_foreign) begin
      nxt = UL_LOCKED;
    end
    return nxt;
  endfunction

  // sticky flags: events set, write-one clears, set wins
  function automatic logic [N_SRC-1:0] flags_next(
    input logic [N_SRC-1:0] cur,
    input logic [N_SRC-1:0] set_v,
    input logic             clr_en,
    input logic [N_SRC-1:0] clr_mask
  );
    logic [N_SRC-1:0] keep;
    keep = clr_en ? (cur & ~clr_mask) : cur;
    return keep | set_v;
  endfunction

endpackage

// File: rtl/rstctl_apb_decode.sv
module rstctl_apb_decode
  import rstctl_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int OFF_CFG = 0,
  parameter int OFF_KEY = 4,
  parameter int OFF_STS = 8
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output logic              sel_cfg,
  output logic              sel_key,
  output logic              sel_sts,
  output logic              wr_cfg,
  output logic              wr_key,
  output logic              wr_foreign
);

  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(OFF_CFG);
  localparam logic [ADDR_W-1:0] A_KEY = ADDR_W'(OFF_KEY);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFF_STS);

  logic wr_stb;

  always_comb begin
    sel_cfg    = (paddr == A_CFG);
    sel_key    = (paddr == A_KEY);
    sel_sts    = (paddr == A_STS);
    wr_stb     = psel & penable & pwrite;
    wr_cfg     = wr_stb & sel_cfg;
    wr_key     = wr_stb & sel_key;
    wr_foreign = wr_stb & ~sel_cfg & ~sel_key;
  end

endmodule

// File: rtl/rstctl_unlock_fsm.sv
module rstctl_unlock_fsm
  import rstctl_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEY_FIRST  = 16'h2009,
  parameter logic [DATA_W-1:0] KEY_SECOND = 16'h0426
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_key,
  input  logic              wr_cfg,
  input  logic              wr_foreign,
  input  logic [DATA_W-1:0] wdata,
  output unlock_e           state,
  output logic              cfg_accept
);

  unlock_e state_d;

  always_comb begin
    state_d    = unlock_next(state, wr_key, wr_cfg, wr_foreign, wdata,
                             KEY_FIRST, KEY_SECOND);
    cfg_accept = wr_cfg & (state == UL_OPEN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= UL_LOCKED;
    else        state <= state_d;
  end

endmodule

// File: rtl/rstctl_cause_flags.sv
module rstctl_cause_flags
  import rstctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_v,
  input  logic             clr_en,
  input  logic [N_SRC-1:0] clr_mask,
  output logic [N_SRC-1:0] flags
);

  localparam logic [N_SRC-1:0] FLAGS_AT_POR = N_SRC'(1) << SRC_POR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= FLAGS_AT_POR;
    else        flags <= flags_next(flags, set_v, clr_en, clr_mask);
  end

endmodule

// File: rtl/rstctl_regs.sv
module rstctl_regs
  import rstctl_pkg::*;
#(
  parameter int                ADDR_W     = 4,
  parameter int                OFF_CFG    = 0,
  parameter int                OFF_KEY    = 4,
  parameter int                OFF_STS    = 8,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 16'h2009,
  parameter logic [DATA_W-1:0] KEY_SECOND = 16'h0426
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic              evt_ext,
  input  logic              evt_wdt,
  input  logic              evt_sw,
  output logic              no_retain
);

  // named internal events, also used by the bound checker
  logic             sel_cfg, sel_key, sel_sts;
  logic             wr_cfg, wr_key, wr_foreign, wr_sts;
  logic             cfg_accept;
  unlock_e          ul_state;
  logic [N_SRC-1:0] ev_vec;
  logic [N_SRC-1:0] flags;
  logic             cfg_q;

  rstctl_apb_decode #(
    .ADDR_W (ADDR_W),
    .OFF_CFG(OFF_CFG),
    .OFF_KEY(OFF_KEY),
    .OFF_STS(OFF_STS)
  ) u_dec (
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .sel_cfg   (sel_cfg),
    .sel_key   (sel_key),
    .sel_sts   (sel_sts),
    .wr_cfg    (wr_cfg),
    .wr_key    (wr_key),
    .wr_foreign(wr_foreign)
  );

  assign wr_sts = wr_foreign & sel_sts;

  rstctl_unlock_fsm #(
    .KEY_FIRST (KEY_FIRST),
    .KEY_SECOND(KEY_SECOND)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (por_n),
    .wr_key    (wr_key),
    .wr_cfg    (wr_cfg),
    .wr_foreign(wr_foreign),
    .wdata     (pwdata),
    .state     (ul_state),
    .cfg_accept(cfg_accept)
  );

  always_comb begin
    ev_vec          = '0;
    ev_vec[SRC_EXT] = evt_ext;
    ev_vec[SRC_WDT] = evt_wdt;
    ev_vec[SRC_SW]  = evt_sw;
  end

  rstctl_cause_flags u_flags (
    .clk     (clk),
    .rst_n   (por_n),
    .set_v   (ev_vec),
    .clr_en  (wr_sts),
    .clr_mask(pwdata[N_SRC-1:0]),
    .flags   (flags)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          cfg_q <= 1'b0;
    else if (cfg_accept) cfg_q <= pwdata[0];
  end

  assign no_retain = cfg_q;

  // read mux; key register always reads zero
  always_comb begin
    prdata = '0;
    if (psel && sel_cfg) prdata[0]         = cfg_q;
    if (psel && sel_sts) prdata[N_SRC-1:0] = flags;
  end

endmodule

// File: rtl/rstctl_regs_chk.sv
module rstctl_regs_chk
  import rstctl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              sel_key,
  input logic              sel_sts,
  input logic              wr_cfg,
  input logic              wr_foreign,
  input logic              wr_sts,
  input logic [DATA_W-1:0] pwdata,
  input logic [DATA_W-1:0] prdata,
  input logic [N_SRC-1:0]  ev_vec,
  input logic [N_SRC-1:0]  flags,
  input logic [1:0]        ul_state,
  input logic              no_retain
);

  logic [N_SRC-1:0] clr_mask;
  assign clr_mask = wr_sts ? pwdata[N_SRC-1:0] : '0;

  // R2: an event leaves its flag set on the next edge
  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_vec) |=> ((flags & $past(ev_vec)) == $past(ev_vec)));

  // R3: a flag only drops when a write-one-to-clear named it
  p_clear_only_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flags) & ~flags & ~$past(clr_mask)) == '0));

  // R3: reserved cause bits read zero
  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && sel_sts) |-> (prdata[DATA_W-1:N_SRC] == '0));

  // R4: event wins over a same-cycle clear
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && |(ev_vec & pwdata[N_SRC-1:0])) |=>
      ((flags & $past(ev_vec)) == $past(ev_vec)));

  // R5: retention output holds unless an open-lock write arrives
  p_locked_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_cfg && ul_state == UL_OPEN) |=> $stable(no_retain));

  // R7: any retention write leaves the lock closed
  p_relock_after_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cfg |=> (ul_state == UL_LOCKED));

  // R9: foreign writes close the lock
  p_foreign_relock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_foreign |=> (ul_state == UL_LOCKED));

  // R10: key register reads zero
  p_key_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && sel_key) |-> (prdata == '0));

endmodule

bind rstctl_regs rstctl_regs_chk u_chk (
  .clk       (clk),
  .rst_n     (por_n),
  .psel      (psel),
  .sel_key   (sel_key),
  .sel_sts   (sel_sts),
  .wr_cfg    (wr_cfg),
  .wr_foreign(wr_foreign),
  .wr_sts    (wr_sts),
  .pwdata    (pwdata),
  .prdata    (prdata),
  .ev_vec    (ev_vec),
  .flags     (flags),
  .ul_state  (ul_state),
  .no_retain (no_retain)
);

// File: tb/rstctl_regs_test.sv
module rstctl_regs_test;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;
  localparam logic [3:0] A_CFG = 4'h0, A_KEY = 4'h4, A_STS = 4'h8, A_NONE = 4'hC;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [3:0]  paddr = '0;
  logic [15:0] pwdata = '0;
  logic [15:0] prdata;
  logic        evt_ext = 1'b0, evt_wdt = 1'b0, evt_sw = 1'b0;
  logic        no_retain;

  always #(CLK_PERIOD/2) clk = ~clk;

  rstctl_regs uut (
    .clk(clk), .por_n(por_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .evt_ext(evt_ext), .evt_wdt(evt_wdt), .evt_sw(evt_sw), .no_retain(no_retain)
  );

  int          n_vec = 0;
  int          n_bad = 0;
  bit          finished = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  task automatic note(input bit ok, input string tag,
                      input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // scoreboard monitor: compares each read in its access phase
  always @(negedge clk) begin
    if (psel && penable && !pwrite) begin
      if (exp_q.size() == 0) note(1'b0, "scoreboard underflow", prdata, 16'h0);
      else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        note(prdata === e, t, prdata, e);
      end
    end
  end

  task automatic apb_write(input logic [3:0] a, input logic [15:0] d,
                           input logic [2:0] ev = 3'b000);
    @(posedge clk); #1;
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(posedge clk); #1;
    penable = 1; {evt_sw, evt_wdt, evt_ext} = ev;
    @(posedge clk); #1;
    psel = 0; penable = 0; pwrite = 0; {evt_sw, evt_wdt, evt_ext} = 3'b000;
  endtask

  task automatic apb_read(input logic [3:0] a, input logic [15:0] exp,
                          input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(posedge clk); #1;
    penable = 1;
    @(posedge clk); #1;
    psel = 0; penable = 0;
  endtask

  task automatic pulse(input logic [2:0] ev);
    @(posedge clk); #1;
    {evt_sw, evt_wdt, evt_ext} = ev;
    @(posedge clk); #1;
    {evt_sw, evt_wdt, evt_ext} = 3'b000;
  endtask

  task automatic check_out(input logic e, input string tag);
    @(negedge clk);
    note(no_retain === e, tag, {15'b0, no_retain}, {15'b0, e});
  endtask

  task automatic unlock();
    apb_write(A_KEY, 16'h2009);
    apb_write(A_KEY, 16'h0426);
  endtask

  task automatic do_por();
    @(posedge clk); #1 por_n = 0;
    repeat (3) @(posedge clk);
    #1 por_n = 1;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    note(1'b0, "watchdog expired", 16'h0, 16'h0);
    summary();
  end

  initial begin
    do_por();
    // R1 reset state
    apb_read(A_STS, 16'h0001, "R1 cause after power-on");
    apb_read(A_CFG, 16'h0000, "R1 retention after power-on");
    check_out(1'b0, "R1 no_retain after power-on");

    // R3 write-0 keeps, write-1 clears
    apb_write(A_STS, 16'h0000);
    apb_read(A_STS, 16'h0001, "R3 write 0 keeps flag");
    apb_write(A_STS, 16'h0001);
    apb_read(A_STS, 16'h0000, "R3 write 1 clears flag");

    // R2 events set their own bits and stick
    pulse(3'b001);
    apb_read(A_STS, 16'h0002, "R2 external sets bit1");
    pulse(3'b010);
    apb_read(A_STS, 16'h0006, "R2 watchdog sets bit2");
    pulse(3'b100);
    apb_read(A_STS, 16'h000E, "R2 software sets bit3");
    apb_write(A_STS, 16'h0004);
    apb_read(A_STS, 16'h000A, "R3 clear only the written bit");
    apb_write(A_STS, 16'hFFFF);
    apb_read(A_STS, 16'h0000, "R3 clear all, reserved read zero");

    // R4 set wins against same-cycle clear
    pulse(3'b001);
    apb_write(A_STS, 16'h0002, 3'b001);
    apb_read(A_STS, 16'h0002, "R4 event beats clear");
    apb_write(A_STS, 16'h0002);
    apb_read(A_STS, 16'h0000, "R4 later clear works");

    // R5 locked write ignored
    apb_write(A_CFG, 16'h0001);
    apb_read(A_CFG, 16'h0000, "R5 locked write ignored");
    check_out(1'b0, "R5 no_retain unchanged");

    // R6 full unlock sequence
    unlock();
    apb_write(A_CFG, 16'h0001);
    apb_read(A_CFG, 16'h0001, "R6 unlocked write taken");
    check_out(1'b1, "R6 no_retain follows");

    // R7 relock after one write
    apb_write(A_CFG, 16'h0000);
    apb_read(A_CFG, 16'h0001, "R7 second write ignored");

    // R10 + R11: key reads zero, reads do not disturb sequence
    apb_write(A_KEY, 16'h2009);
    apb_read(A_KEY, 16'h0000, "R10 key reads zero after first key");
    apb_write(A_KEY, 16'h0426);
    apb_read(A_STS, 16'h0000, "R11 status read mid-sequence");
    apb_read(A_KEY, 16'h0000, "R10 key reads zero when open");
    apb_write(A_CFG, 16'h0000);
    apb_read(A_CFG, 16'h0000, "R11 write taken after reads");
    check_out(1'b0, "R11 no_retain cleared");

    // R8 wrong keys and repeated first key
    apb_write(A_KEY, 16'h2009);
    apb_write(A_KEY, 16'h1234);
    apb_write(A_KEY, 16'h0426);
    apb_write(A_CFG, 16'h0001);
    apb_read(A_CFG, 16'h0000, "R8 wrong second key relocks");
    apb_write(A_KEY, 16'h1111);
    apb_write(A_KEY, 16'h0426);
    apb_write(A_CFG, 16'h0001);
    apb_read(A_CFG, 16'h0000, "R8 wrong first key stays locked");
    apb_write(A_KEY, 16'h2009);
    apb_write(A_KEY, 16'h2009);
    apb_write(A_KEY, 16'h0426);
    apb_write(A_CFG, 16'h0001);
    apb_read(A_CFG, 16'h0001, "R8 repeated first key restarts");

    // R9 foreign writes relock
    unlock();
    apb_write(A_STS, 16'h0000);
    apb_write(A_CFG, 16'h0000);
    apb_read(A_CFG, 16'h0001, "R9 status write relocks open state");
    apb_write(A_KEY, 16'h2009);
    apb_write(A_NONE, 16'h0000);
    apb_write(A_KEY, 16'h0426);
    apb_write(A_CFG, 16'h0000);
    apb_read(A_CFG, 16'h0001, "R9 unmapped write relocks after first key");
    check_out(1'b1, "R9 no_retain kept");

    // R1 power-on clears retention and warm flags
    pulse(3'b110);
    apb_read(A_STS, 16'h000C, "R2 flags before power-on");
    do_por();
    apb_read(A_STS, 16'h0001, "R1 only power-on flag after reset");
    apb_read(A_CFG, 16'h0000, "R1 retention cleared by power-on");
    check_out(1'b0, "R1 no_retain cleared by power-on");

    @(negedge clk);
    if (exp_q.size() != 0) note(1'b0, "scoreboard leftover", 16'(exp_q.size()), 16'h0);
    summary();
  end

endmodule